// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an addressing-mode selector and the operands a decoder has already gathered into the byte address of a memory operand. It receives one request per cycle: a 3-bit mode, an operand size, up to two register values, a displacement from the instruction and the current program counter. One clock later it returns the registered effective address. It also returns flags that tell the pipeline whether a memory access is needed at all, and whether the operand is a literal carried in the instruction.

For the post-increment and pre-decrement pointer modes, the block also returns the new pointer value and a write-back strobe, so the register file can update the pointer in the same cycle it receives the address. The pointer moves by the operand size. All address arithmetic wraps at the address width.

The block does not access memory, decode instructions or hold any registers. It covers only the address arithmetic and the pointer side effect.

Top module: `ea_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls with no request, `out_valid`, `wb_en`, `no_mem` and `is_imm` are all 0.
- R2: The results for a request presented with `req_valid`=1 appear in the next cycle, with `out_valid`=1. A cycle without a request gives `out_valid`=0 one cycle later.
- R3: Mode 0 (literal) sets `is_imm`=1 and `no_mem`=1. Mode 1 (register operand) sets `no_mem`=1 and `is_imm`=0. Modes 2 to 7 set both flags to 0. `ea` is undefined when `no_mem`=1.
- R4: Mode 2 (absolute) gives `ea` = `disp` zero-extended to the address width.
- R5: Mode 3 (pointer in register) gives `ea` = `reg_a`.
- R6: Mode 4 (indexed) gives `ea` = `reg_a` + `disp` sign-extended, so a displacement with its top bit set is negative.
- R7: Mode 5 (base plus index plus offset) gives `ea` = `reg_a` + `reg_b` + `disp` sign-extended. A zero `disp` gives the two-register form.
- R8: Mode 6 (program-relative) gives `ea` = `pc` + `disp` sign-extended, and negative offsets are allowed.
- R9: Mode 7 with `dec_sel`=0 gives `ea` = `reg_a` and `wb_val` = `reg_a` + step. The step is set by `op_size`: 1 for code 0 (byte), 2 for code 1 (halfword), 4 for code 2 (word), and 4 for the reserved code 3.
- R10: Mode 7 with `dec_sel`=1 gives `ea` = `wb_val` = `reg_a` - step, with the step taken from `op_size` as in R9.
- R11: All sums and differences wrap modulo 2^ADDR_W and raise no flag.
- R12: `wb_en` is 1 only in the cycle that returns a mode-7 request. For every other mode, and for idle cycles, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| mode | input | 3 | Addressing mode selector |
| dec_sel | input | 1 | In mode 7, selects pre-decrement instead of post-increment |
| op_size | input | 2 | Operand size code (0 byte, 1 halfword, 2 word) |
| reg_a | input | ADDR_W | Primary register value (base or pointer) |
| reg_b | input | ADDR_W | Second register value (index) |
| disp | input | DISP_W | Displacement or absolute address field |
| pc | input | ADDR_W | Current program counter |
| out_valid | output | 1 | Results for last cycle's request are valid |
| ea | output | ADDR_W | Effective address |
| no_mem | output | 1 | The operand needs no memory access |
| is_imm | output | 1 | The operand is the instruction field itself |
| wb_en | output | 1 | Write `wb_val` back to the pointer register |
| wb_val | output | ADDR_W | Updated pointer value |

## Verification
The embedded assertions check, on every cycle, the one-cycle request-to-result timing. They also check that the write-back strobe and the two flags appear only with valid results and the right mode, that a pre-decrement returns the same value on both address and pointer outputs, and that a post-increment moves the pointer by exactly one power of two no larger than four. The actual sums for each mode can only be shown by the bench's directed scenarios: sign extension of negative displacements, the three-operand sum, the size-to-step mapping including the reserved code, and wraparound at both ends of the address space.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    AM_LIT  = 3'd0,
    AM_REG  = 3'd1,
    AM_ABS  = 3'd2,
    AM_PTR  = 3'd3,
    AM_IDX  = 3'd4,
    AM_BIX  = 3'd5,
    AM_PCR  = 3'd6,
    AM_STEP = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSV  = 2'd3
  } osize_e;
endpackage

// File: rtl/ea_extend.sv
module ea_extend #(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 32,
  parameter bit SIGNED = 1'b1
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      logic fill;
      assign fill = SIGNED ? din[IN_W-1] : 1'b0;
      assign dout = {{PAD_W{fill}}, din};
    end else begin : g_same
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ea_step_gen.sv
module ea_step_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        op_size,
  input  logic              dec_sel,
  output logic [ADDR_W-1:0] delta
);
  logic [ADDR_W-1:0] step;

  always_comb begin
    step = '0;
    case (osize_e'(op_size))
      SZ_BYTE: step[0] = 1'b1;
      SZ_HALF: step[1] = 1'b1;
      default: step[2] = 1'b1;
    endcase
  end

  assign delta = dec_sel ? ('0 - step) : step;
endmodule

// File: rtl/ea_adder3.sv
module ea_adder3 #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum
);
  assign sum = a + b + c;
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        mode,
  input  logic              dec_sel,
  input  logic [1:0]        op_size,
  input  logic [ADDR_W-1:0] reg_a,
  input  logic [ADDR_W-1:0] reg_b,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] pc,
  output logic              out_valid,
  output logic [ADDR_W-1:0] ea,
  output logic              no_mem,
  output logic              is_imm,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_val
);
  amode_e am;
  assign am = amode_e'(mode);

  logic [ADDR_W-1:0] disp_sx, disp_zx, delta, ptr_next;
  logic [ADDR_W-1:0] add_a, add_b, add_c, add_sum, ea_d;
  logic              no_mem_d, imm_d, wb_en_d;

  ea_extend #(.IN_W(DISP_W), .OUT_W(ADDR_W), .SIGNED(1'b1)) u_sx (.din(disp), .dout(disp_sx));
  ea_extend #(.IN_W(DISP_W), .OUT_W(ADDR_W), .SIGNED(1'b0)) u_zx (.din(disp), .dout(disp_zx));

  ea_step_gen #(.ADDR_W(ADDR_W)) u_step (.op_size(op_size), .dec_sel(dec_sel), .delta(delta));

  ea_adder3 #(.W(ADDR_W)) u_main_add (.a(add_a), .b(add_b), .c(add_c), .sum(add_sum));
  ea_adder3 #(.W(ADDR_W)) u_ptr_add  (.a(reg_a), .b(delta), .c('0), .sum(ptr_next));

  always_comb begin
    add_a    = '0;
    add_b    = '0;
    add_c    = '0;
    no_mem_d = 1'b0;
    imm_d    = 1'b0;
    wb_en_d  = 1'b0;
    case (am)
      AM_LIT:  begin no_mem_d = 1'b1; imm_d = 1'b1; end
      AM_REG:  no_mem_d = 1'b1;
      AM_ABS:  add_a = disp_zx;
      AM_PTR:  add_a = reg_a;
      AM_IDX:  begin add_a = reg_a; add_b = disp_sx; end
      AM_BIX:  begin add_a = reg_a; add_b = reg_b; add_c = disp_sx; end
      AM_PCR:  begin add_a = pc; add_b = disp_sx; end
      default: wb_en_d = 1'b1;
    endcase
  end

  assign ea_d = (am == AM_STEP) ? (dec_sel ? ptr_next : reg_a) : add_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      no_mem    <= 1'b0;
      is_imm    <= 1'b0;
      wb_en     <= 1'b0;
      ea        <= '0;
      wb_val    <= '0;
    end else begin
      out_valid <= req_valid;
      no_mem    <= req_valid & no_mem_d;
      is_imm    <= req_valid & imm_d;
      wb_en     <= req_valid & wb_en_d;
      if (req_valid) begin
        ea     <= ea_d;
        wb_val <= ptr_next;
      end
    end
  end

  logic [ADDR_W-1:0] ptr_move;
  assign ptr_move = wb_val - ea;

  // R2
  req_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R2
  idle_to_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  // R12
  wb_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && (mode != 3'd7) |=> !wb_en);

  // R12
  wb_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> out_valid);

  // R3
  flags_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (no_mem || is_imm) |-> out_valid);

  // R3
  imm_implies_nomem_chk: assert property (@(posedge clk) disable iff (rst)
    is_imm |-> no_mem);

  // R10
  predec_match_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && (mode == 3'd7) && dec_sel |=> wb_en && (wb_val == ea));

  // R9
  postinc_step_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && (mode == 3'd7) && !dec_sel |=>
      wb_en && ($countones(ptr_move) == 1) && (ptr_move <= 4));
endmodule

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  mode;
  logic        dec_sel;
  logic [1:0]  op_size;
  logic [31:0] reg_a, reg_b, pc;
  logic [15:0] disp;
  logic        out_valid, no_mem, is_imm, wb_en;
  logic [31:0] ea, wb_val;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ea_unit #(.ADDR_W(32), .DISP_W(16)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .dec_sel(dec_sel),
    .op_size(op_size), .reg_a(reg_a), .reg_b(reg_b), .disp(disp), .pc(pc),
    .out_valid(out_valid), .ea(ea), .no_mem(no_mem), .is_imm(is_imm),
    .wb_en(wb_en), .wb_val(wb_val)
  );

  function automatic logic [31:0] sx(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic d, input logic [1:0] s,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] dp, input logic [31:0] p);
    @(negedge clk);
    req_valid = 1'b1; mode = m; dec_sel = d; op_size = s;
    reg_a = a; reg_b = b; disp = dp; pc = p;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b0; mode = '0; dec_sel = 1'b0; op_size = '0;
    reg_a = '0; reg_b = '0; disp = '0; pc = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'b0, out_valid}, 32'd0);
    check("R1 wb_en in reset", {31'b0, wb_en}, 32'd0);
    check("R1 flags in reset", {30'b0, no_mem, is_imm}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after release", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_flags();
    issue(3'd0, 1'b0, 2'd2, 32'h10, 32'h0, 16'h5, 32'h0);
    check("R2 valid after request", {31'b0, out_valid}, 32'd1);
    check("R3 literal flags", {30'b0, no_mem, is_imm}, 32'd3);
    check("R12 literal wb_en", {31'b0, wb_en}, 32'd0);
    issue(3'd1, 1'b0, 2'd2, 32'h10, 32'h0, 16'h5, 32'h0);
    check("R3 register flags", {30'b0, no_mem, is_imm}, 32'd2);
    issue(3'd3, 1'b0, 2'd2, 32'h10, 32'h0, 16'h5, 32'h0);
    check("R3 memory mode flags", {30'b0, no_mem, is_imm}, 32'd0);
    @(negedge clk);
    check("R2 idle gives no valid", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_simple();
    issue(3'd2, 1'b0, 2'd2, 32'hDEAD0000, 32'h0, 16'h8004, 32'h0);
    check("R4 absolute zero-extended", ea, 32'h0000_8004);
    issue(3'd3, 1'b0, 2'd2, 32'h0001_0000, 32'h0, 16'h7777, 32'h0);
    check("R5 pointer in register", ea, 32'h0001_0000);
    check("R12 pointer mode wb_en", {31'b0, wb_en}, 32'd0);
  endtask

  task automatic t_index();
    issue(3'd4, 1'b0, 2'd2, 32'h0001_0000, 32'h0, 16'h0020, 32'h0);
    check("R6 indexed positive", ea, 32'h0001_0000 + sx(16'h0020));
    issue(3'd4, 1'b0, 2'd2, 32'h0001_0000, 32'h0, 16'hFFF0, 32'h0);
    check("R6 indexed negative", ea, 32'h0000_FFF0);
    issue(3'd5, 1'b0, 2'd2, 32'h0001_0000, 32'h0000_0300, 16'hFFFC, 32'h0);
    check("R7 base index offset", ea, 32'h0001_02FC);
    issue(3'd5, 1'b0, 2'd2, 32'h0000_1000, 32'h0000_0024, 16'h0000, 32'h0);
    check("R7 two-register form", ea, 32'h0000_1024);
  endtask

  task automatic t_pcrel();
    issue(3'd6, 1'b0, 2'd2, 32'h5555, 32'h0, 16'h0100, 32'h0000_2000);
    check("R8 relative forward", ea, 32'h0000_2100);
    issue(3'd6, 1'b0, 2'd2, 32'h5555, 32'h0, 16'hFF00, 32'h0000_2000);
    check("R8 relative backward", ea, 32'h0000_1F00);
  endtask

  task automatic t_autoinc();
    for (int s = 0; s < 4; s++) begin
      logic [31:0] st;
      st = (s == 0) ? 32'd1 : (s == 1) ? 32'd2 : 32'd4;
      issue(3'd7, 1'b0, s[1:0], 32'h0000_4000, 32'h0, 16'h0, 32'h0);
      check($sformatf("R9 post-inc addr size %0d", s), ea, 32'h0000_4000);
      check($sformatf("R9 post-inc pointer size %0d", s), wb_val, 32'h0000_4000 + st);
      check("R12 step mode wb_en", {31'b0, wb_en}, 32'd1);
    end
  endtask

  task automatic t_autodec();
    for (int s = 0; s < 3; s++) begin
      logic [31:0] st;
      st = (s == 0) ? 32'd1 : (s == 1) ? 32'd2 : 32'd4;
      issue(3'd7, 1'b1, s[1:0], 32'h0000_4000, 32'h0, 16'h0, 32'h0);
      check($sformatf("R10 pre-dec addr size %0d", s), ea, 32'h0000_4000 - st);
      check($sformatf("R10 pre-dec pointer size %0d", s), wb_val, 32'h0000_4000 - st);
    end
  endtask

  task automatic t_wrap();
    issue(3'd4, 1'b0, 2'd2, 32'hFFFF_FFFE, 32'h0, 16'h0004, 32'h0);
    check("R11 index wraps high", ea, 32'h0000_0002);
    issue(3'd7, 1'b1, 2'd2, 32'h0000_0000, 32'h0, 16'h0, 32'h0);
    check("R11 pre-dec wraps low", ea, 32'hFFFF_FFFC);
    issue(3'd7, 1'b0, 2'd0, 32'hFFFF_FFFF, 32'h0, 16'h0, 32'h0);
    check("R11 post-inc wraps high", wb_val, 32'h0000_0000);
    @(negedge clk);
    check("R12 idle wb_en", {31'b0, wb_en}, 32'd0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL R2 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_flags();
    t_simple();
    t_index();
    t_pcrel();
    t_autoinc();
    t_autodec();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule